// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block is the register file behind a four-channel digitally controlled resistor. Each channel owns one wiper register, whose value sets the resistor tap and appears on an output, and four stored data registers that hold preset positions. A single status register decides where channel accesses go. With its target bit clear, a channel address reaches that channel's wiper. With the bit set, a channel address reaches one data register row, chosen by two row bits.

Setting the target bit has a side effect. The same status write copies the chosen row of presets into all four wiper registers at once. A host can therefore recall a full set of positions with a single byte write.

The host port is a plain parallel command interface. It accepts one command per cycle. A command carries a valid strobe, a write flag, an 8-bit address and 8-bit write data. Each read returns its data with a valid flag one cycle after the command is accepted.

Top module: `quad_wiper_bank`

## Requirements
- R1: After reset, the status register, every wiper and every data register hold 00h, and `rd_valid` is 0. Channel accesses then go to the wipers.
- R2: The status register is at address 07h. A status write stores only bits 2:0 of the data, and a status read returns that value with bits 7:3 as zero.
- R3: A status write with bit 0 = 1 copies data register row `wdata[2:1]` of every channel into that channel's wiper. The new values are on `wiper_out` after the clock edge that accepts the write.
- R4: While status bit 0 = 0, a write to channel address 00h..03h changes only that channel's wiper. The wiper of channel c is `wiper_out[8c+7:8c]`.
- R5: While status bit 0 = 1, a write to channel address c stores the data in row status[2:1] of channel c. No wiper changes.
- R6: A read of channel address c returns that channel's wiper when status bit 0 = 0. It returns data register row status[2:1] of channel c when status bit 0 = 1.
- R7: Writes to addresses 04h..06h and 08h..FFh change no register. Reads from those addresses return 00h.
- R8: A status write with bit 0 = 0 leaves every wiper unchanged.
- R9: `rd_valid` is 1 in the cycle after a read command is accepted and 0 after any other cycle. Its `rd_data` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe; one command per cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read command |
| wiper_out | output | 32 | Four wiper values, channel c in bits 8c+7:8c |

## Verification
The row recall is tried with distinct values loaded into two different rows. This confirms that the row bits pick the row and that all four channels load in the same cycle. It also shows that the recall overwrites wipers set by earlier direct writes.

Channel writes are made under both target settings. These show whether an access reaches the wiper or the data register, and whether it touches any neighbouring channel. Status values with the reserved bits set, and a status write with the target bit clear, show that the extra bits are discarded and that only the target bit triggers a copy. Writes to reserved addresses are followed by reads of every real register, which shows that nothing was changed.

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank #(
  parameter int CHANNELS    = 4,
  parameter int ROWS        = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int STATUS_ADDR = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic                       cmd_write,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [DATA_W-1:0]          cmd_wdata,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_valid,
  output logic [CHANNELS*DATA_W-1:0] wiper_out
);
  localparam int CH_W  = $clog2(CHANNELS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int ST_W  = ROW_W + 1;

  logic [ST_W-1:0]   status;
  logic [DATA_W-1:0] wcr [CHANNELS];
  logic [DATA_W-1:0] dr  [CHANNELS][ROWS];
  logic [DATA_W-1:0] rd_next;

  wire              is_status = cmd_addr == ADDR_W'(STATUS_ADDR);
  wire              is_chan   = cmd_addr < ADDR_W'(CHANNELS);
  wire [CH_W-1:0]   chan      = cmd_addr[CH_W-1:0];
  wire              to_dr     = status[0];
  wire [ROW_W-1:0]  row       = status[ST_W-1:1];
  wire [ROW_W-1:0]  new_row   = cmd_wdata[ST_W-1:1];
  wire              wr        = cmd_valid && cmd_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      for (int c = 0; c < CHANNELS; c++) begin
        wcr[c] <= '0;
        for (int r = 0; r < ROWS; r++) dr[c][r] <= '0;
      end
    end else if (wr) begin
      if (is_status) begin
        status <= cmd_wdata[ST_W-1:0];
        if (cmd_wdata[0])
          for (int c = 0; c < CHANNELS; c++) wcr[c] <= dr[c][new_row];
      end else if (is_chan) begin
        if (to_dr) dr[chan][row] <= cmd_wdata;
        else       wcr[chan]     <= cmd_wdata;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (is_status)    rd_next = DATA_W'(status);
    else if (is_chan) rd_next = to_dr ? dr[chan][row] : wcr[chan];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cmd_valid && !cmd_write;
      if (cmd_valid && !cmd_write) rd_data <= rd_next;
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_out
    assign wiper_out[c*DATA_W +: DATA_W] = wcr[c];
  end
endmodule

module quad_wiper_bank_chk #(
  parameter int CHANNELS    = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int STATUS_ADDR = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       cmd_write,
  input logic [ADDR_W-1:0]          cmd_addr,
  input logic [DATA_W-1:0]          cmd_wdata,
  input logic [DATA_W-1:0]          rd_data,
  input logic                       rd_valid,
  input logic [CHANNELS*DATA_W-1:0] wiper_out
);
  wire is_st  = cmd_addr == ADDR_W'(STATUS_ADDR);
  wire is_res = !is_st && cmd_addr >= ADDR_W'(CHANNELS);

  a_r9_rd_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write) |=> rd_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_write) |=> !rd_valid);
  a_r7_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && is_res) |=> rd_data == '0);
  a_r2_status_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && is_st) |=> rd_data[DATA_W-1:3] == '0);
  a_r8_status_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && is_st && !cmd_wdata[0]) |=> $stable(wiper_out));
  a_r7_reserved_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && is_res) |=> $stable(wiper_out));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_iso
    a_r4_wiper_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write && !is_st && cmd_addr != ADDR_W'(c))
      |=> $stable(wiper_out[c*DATA_W +: DATA_W]));
  end
endmodule

bind quad_wiper_bank quad_wiper_bank_chk #(
  .CHANNELS(CHANNELS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (.*);

// File: tb/tb_quad_wiper_bank.sv
module tb_quad_wiper_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_write = 0;
  logic [7:0]  cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [31:0] wiper_out;
  int errors = 0;
  int checks = 0;

  quad_wiper_bank dut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
    check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
    check({req, " rd_data"}, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset();
    check("R1 wipers after reset", wiper_out, 32'h0);
    check("R1 rd_valid after reset", 32'(rd_valid), 0);
    rd("R1 status", 8'h07, 8'h00);
    for (int c = 0; c < 4; c++) rd("R1 wiper read", 8'(c), 8'h00);
    wr(8'h07, 8'h01);
    for (int c = 0; c < 4; c++) rd("R1 dr row0", 8'(c), 8'h00);
    wr(8'h07, 8'h00);
  endtask

  task automatic t_direct_wiper();
    wr(8'h01, 8'h5A);
    check("R4 only ch1 changes", wiper_out, 32'h0000_5A00);
    wr(8'h03, 8'hC3);
    check("R4 only ch3 changes", wiper_out, 32'hC300_5A00);
    rd("R6 wiper ch1", 8'h01, 8'h5A);
    @(negedge clk);
    check("R9 idle no valid", 32'(rd_valid), 0);
  endtask

  task automatic t_dr_write();
    wr(8'h07, 8'h05);
    check("R3 row2 zero copy", wiper_out, 32'h0);
    for (int c = 0; c < 4; c++) begin
      wr(8'(c), 8'(8'h11 * (c + 1)));
      check("R9 write no valid", 32'(rd_valid), 0);
    end
    check("R5 wipers untouched", wiper_out, 32'h0);
    rd("R6 dr row2 ch2", 8'h02, 8'h33);
    rd("R2 status readback", 8'h07, 8'h05);
    wr(8'h07, 8'h03);
    for (int c = 0; c < 4; c++) wr(8'(c), 8'(8'hA0 + c));
    rd("R6 dr row1 ch3", 8'h03, 8'hA3);
  endtask

  task automatic t_copy();
    wr(8'h07, 8'h00);
    for (int c = 0; c < 4; c++) wr(8'(c), 8'hF0);
    check("R4 wipers set", wiper_out, 32'hF0F0_F0F0);
    wr(8'h07, 8'h05);
    check("R3 row2 copied", wiper_out, 32'h4433_2211);
    wr(8'h07, 8'h03);
    check("R3 row1 copied", wiper_out, 32'hA3A2_A1A0);
    wr(8'h07, 8'h04);
    check("R8 no copy bit0=0", wiper_out, 32'hA3A2_A1A0);
    rd("R6 wiper target", 8'h00, 8'hA0);
  endtask

  task automatic t_reserved_status();
    wr(8'h07, 8'hFB);
    rd("R2 reserved bits dropped", 8'h07, 8'h03);
    check("R3 copy with junk bits", wiper_out, 32'hA3A2_A1A0);
    rd("R2 row from bits2:1", 8'h01, 8'hA1);
  endtask

  task automatic t_reserved_addr();
    wr(8'h07, 8'h00);
    wr(8'h04, 8'h77); wr(8'h06, 8'h77); wr(8'h08, 8'h77); wr(8'hFF, 8'h77);
    check("R7 wipers unchanged", wiper_out, 32'hA3A2_A1A0);
    rd("R7 status unchanged", 8'h07, 8'h00);
    rd("R7 read 04h", 8'h04, 8'h00);
    rd("R7 read 06h", 8'h06, 8'h00);
    rd("R7 read 80h", 8'h80, 8'h00);
    wr(8'h07, 8'h05);
    for (int c = 0; c < 4; c++) rd("R7 dr row2 intact", 8'(c), 8'(8'h11 * (c + 1)));
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_direct_wiper();
    t_dr_write();
    t_copy();
    t_reserved_status();
    t_reserved_addr();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule